// File: doc/BRIEF.md
# Two-Speed Coarse/Fine Angle Error Selector

This block chooses which angle error drives a two-speed tracking loop. Each clock it sees three 16-bit angles, all binary fractions of one turn: the coarse (one-per-turn) measured angle, the fine measured angle that turns RATIO times per revolution, and the loop's current counter angle. From these it forms a coarse error and a fine error, both as wrapped signed differences. The fine error compares the fine input against the counter angle scaled by the speed ratio, taken modulo one turn.

A crossover stage looks at the coarse error. Far from null it hands the coarse error to the loop, with a fixed positive shift added so that the half-turn point can never be a resting null. Close to null it hands over the fine error, whose gradient is RATIO times steeper. The chosen error, a fine-mode flag and a built-in-test bit are registered and leave the block one clock after the inputs they came from. The test bit is high whenever the loop is outside the fine-speed capture range.

Top module: `two_speed_err_sel`

## Requirements
- R1: While `rst_n` is low, and after it is released until the first active edge, `err_out` is 0, `fine_mode` is 0 and `bit_fail` is 1; reset acts without waiting for a clock edge.
- R2: The coarse error is `coarse_ang - cnt_ang` taken modulo 2^16 and read as a signed 16-bit value; when its magnitude is at most THR_LSB (default 460), `fine_mode` is 1 after the next rising edge.
- R3: When the magnitude of the coarse error exceeds THR_LSB, `fine_mode` is 0 after the next rising edge; a coarse error of exactly -32768 (half a turn) counts as beyond the threshold.
- R4: In fine mode `err_out` equals `fine_ang - ((cnt_ang * RATIO) mod 2^16)` taken modulo 2^16 as a signed value, with RATIO defaulting to 36; a result of -32768 is passed unchanged.
- R5: In coarse mode `err_out` equals the coarse error plus OFS_LSB + BIAS_LSB (defaults 455 and 4), taken modulo 2^16; at half a turn the output is -32309 and not zero.
- R6: `bit_fail` is always the inverse of `fine_mode`.
- R7: The crossover comparison uses the coarse error without the added shift, so a coarse error of -461 gives coarse mode with `err_out` = -2, while -459 (where the shifted coarse error is 0) gives fine mode.
- R8: The mode is re-decided every cycle; it stays fine while the coarse error remains within the threshold, falls back to coarse on the first cycle it exceeds it, and returns to fine once back inside.
- R9: Lowering `rst_n` during operation returns the outputs to the R1 values at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| coarse_ang | input | 16 | Coarse measured angle, fraction of a turn |
| fine_ang | input | 16 | Fine measured angle, fraction of a fine cycle |
| cnt_ang | input | 16 | Current loop counter angle |
| err_out | output | 16 | Selected signed error, registered |
| fine_mode | output | 1 | 1 when the fine error is selected |
| bit_fail | output | 1 | Built-in-test bit, 1 when not tracking in fine range |

## Verification
A vector table sets the coarse error just inside, exactly on and just past both edges of the threshold. This separates a correct magnitude comparison from one that is off by one, uses the wrong sign, or drops the comparison's offset compensation. Further rows place the two angles half a turn apart, at the largest positive difference and across the zero wrap. These expose missing wrap handling in the coarse shift, and show whether the half turn is wrongly treated as a null. Counter angles whose scaled product overflows 16 bits, including one that yields exactly -32768, test the modulo behaviour of the fine path. Directed steps in and out of the window, plus a reset applied mid-run, show that the mode follows the coarse error from cycle to cycle and that reset takes effect immediately.

// File: rtl/xsel_pkg.sv
package xsel_pkg;
  typedef enum logic {
    M_COARSE = 1'b0,
    M_FINE   = 1'b1
  } xmode_e;
endpackage

// File: rtl/xsel_coarse.sv
// Coarse channel: wrapped error, shifted drive and capture-window test.
module xsel_coarse #(
  parameter int W        = 16,
  parameter int THR_LSB  = 460,
  parameter int OFS_LSB  = 455,
  parameter int BIAS_LSB = 4
) (
  input  logic [W-1:0] coarse_ang,
  input  logic [W-1:0] cnt_ang,
  output logic [W-1:0] drive,
  output logic         near
);
  localparam logic [W-1:0] SHIFT = W'(OFS_LSB + BIAS_LSB);
  localparam logic [W:0]   LIMIT = (W+1)'(THR_LSB);

  logic [W-1:0] diff;
  logic [W:0]   diff_x;
  logic [W:0]   mag;

  always_comb begin
    diff   = coarse_ang - cnt_ang;
    diff_x = {diff[W-1], diff};
    mag    = diff[W-1] ? (~diff_x + 1'b1) : diff_x;
    near   = (mag <= LIMIT);
    drive  = diff + SHIFT;
  end
endmodule

// File: rtl/xsel_fine.sv
// Fine channel: counter angle scaled by the speed ratio, modulo one turn.
module xsel_fine #(
  parameter int W     = 16,
  parameter int RATIO = 36
) (
  input  logic [W-1:0] fine_ang,
  input  logic [W-1:0] cnt_ang,
  output logic [W-1:0] err
);
  logic [W-1:0] scaled;

  always_comb begin
    scaled = W'(cnt_ang * RATIO);
    err    = fine_ang - scaled;
  end
endmodule

// File: rtl/xsel_mode.sv
// Crossover decision and output registers.
module xsel_mode #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         near,
  input  logic [W-1:0] coarse_drive,
  input  logic [W-1:0] fine_err,
  output logic [W-1:0] err_q,
  output logic         fine_q
);
  import xsel_pkg::*;

  xmode_e       mode_q, mode_n;
  logic [W-1:0] err_n;
  logic         upd_en;

  always_comb begin
    upd_en = 1'b1;
    mode_n = near ? M_FINE : M_COARSE;
    err_n  = (mode_n == M_FINE) ? fine_err : coarse_drive;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= M_COARSE;
      err_q  <= '0;
    end else if (upd_en) begin
      mode_q <= mode_n;
      err_q  <= err_n;
    end
  end

  assign fine_q = (mode_q == M_FINE);
endmodule

// File: rtl/two_speed_err_sel.sv
module two_speed_err_sel #(
  parameter int W        = 16,
  parameter int RATIO    = 36,
  parameter int THR_LSB  = 460,
  parameter int OFS_LSB  = 455,
  parameter int BIAS_LSB = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [15:0]  coarse_ang,
  input  logic [15:0]  fine_ang,
  input  logic [15:0]  cnt_ang,
  output logic [15:0]  err_out,
  output logic         fine_mode,
  output logic         bit_fail
);
  logic [W-1:0] c_drive;
  logic [W-1:0] f_err;
  logic         c_near;

  xsel_coarse #(
    .W(W), .THR_LSB(THR_LSB), .OFS_LSB(OFS_LSB), .BIAS_LSB(BIAS_LSB)
  ) u_coarse (
    .coarse_ang (coarse_ang),
    .cnt_ang    (cnt_ang),
    .drive      (c_drive),
    .near       (c_near)
  );

  xsel_fine #(.W(W), .RATIO(RATIO)) u_fine (
    .fine_ang (fine_ang),
    .cnt_ang  (cnt_ang),
    .err      (f_err)
  );

  xsel_mode #(.W(W)) u_mode (
    .clk          (clk),
    .rst_n        (rst_n),
    .near         (c_near),
    .coarse_drive (c_drive),
    .fine_err     (f_err),
    .err_q        (err_out),
    .fine_q       (fine_mode)
  );

  assign bit_fail = ~fine_mode;
endmodule

// File: rtl/xsel_chk.sv
module xsel_chk #(
  parameter int W        = 16,
  parameter int RATIO    = 36,
  parameter int THR_LSB  = 460,
  parameter int OFS_LSB  = 455,
  parameter int BIAS_LSB = 4
) (
  input logic         clk,
  input logic         rst_n,
  input logic [W-1:0] coarse_ang,
  input logic [W-1:0] fine_ang,
  input logic [W-1:0] cnt_ang,
  input logic [W-1:0] err_out,
  input logic         fine_mode,
  input logic         bit_fail
);
  logic signed [W-1:0] cd;
  logic        [W-1:0] fe;
  logic        [W-1:0] cdrv;
  logic                in_win;

  always_comb begin
    cd     = $signed(coarse_ang - cnt_ang);
    in_win = (cd >= -THR_LSB) && (cd <= THR_LSB);
    fe     = fine_ang - W'(cnt_ang * RATIO);
    cdrv   = coarse_ang - cnt_ang + W'(OFS_LSB + BIAS_LSB);
  end

  // R2
  a_r2_enter_fine: assert property (@(posedge clk) disable iff (!rst_n)
    in_win |=> (fine_mode && !bit_fail));
  // R3, R6
  a_r3_leave_fine: assert property (@(posedge clk) disable iff (!rst_n)
    !in_win |=> (!fine_mode && bit_fail));
  // R4
  a_r4_fine_err: assert property (@(posedge clk) disable iff (!rst_n)
    in_win |=> (err_out == $past(fe)));
  // R5
  a_r5_coarse_drive: assert property (@(posedge clk) disable iff (!rst_n)
    !in_win |=> (err_out == $past(cdrv)));
endmodule

bind two_speed_err_sel xsel_chk #(
  .W(W), .RATIO(RATIO), .THR_LSB(THR_LSB), .OFS_LSB(OFS_LSB), .BIAS_LSB(BIAS_LSB)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .coarse_ang (coarse_ang),
  .fine_ang   (fine_ang),
  .cnt_ang    (cnt_ang),
  .err_out    (err_out),
  .fine_mode  (fine_mode),
  .bit_fail   (bit_fail)
);

// File: tb/two_speed_err_sel_tb.sv
`timescale 1ns/1ps
module two_speed_err_sel_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 11;

  // {coarse, fine, counter, expected error, expected fine flag}
  localparam logic [79:0] VEC [NVEC] = '{
    {16'h1000, 16'h4010, 16'h1000, 16'h0010, 16'h0001},  // R2 R4 on null
    {16'h11CC, 16'h3FFB, 16'h1000, 16'hFFFB, 16'h0001},  // R2 edge +460
    {16'h11CD, 16'h0000, 16'h1000, 16'h0398, 16'h0000},  // R3 +461, R5
    {16'h0E34, 16'h4000, 16'h1000, 16'h0000, 16'h0001},  // R2 edge -460
    {16'h0E33, 16'h0000, 16'h1000, 16'hFFFE, 16'h0000},  // R7 -461
    {16'h0E35, 16'h4007, 16'h1000, 16'h0007, 16'h0001},  // R7 -459
    {16'h8000, 16'h0000, 16'h0000, 16'h81CB, 16'h0000},  // R3 R5 half turn
    {16'h0010, 16'h0000, 16'hFFF0, 16'h0240, 16'h0001},  // R2 R4 wrap
    {16'h7FFF, 16'h0000, 16'h0000, 16'h81CA, 16'h0000},  // R5 drive wraps
    {16'h2000, 16'h0000, 16'h2000, 16'h8000, 16'h0001},  // R4 -32768
    {16'h1234, 16'h8FB4, 16'h1234, 16'h0064, 16'h0001}   // R4 product wrap
  };

  logic        clk;
  logic        rst_n;
  logic [15:0] coarse_ang, fine_ang, cnt_ang;
  logic [15:0] err_out;
  logic        fine_mode, bit_fail;
  int          n_run;
  int          n_fail;
  bit          done;

  two_speed_err_sel u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .coarse_ang (coarse_ang),
    .fine_ang   (fine_ang),
    .cnt_ang    (cnt_ang),
    .err_out    (err_out),
    .fine_mode  (fine_mode),
    .bit_fail   (bit_fail)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic chk_out(input string tag, input logic [15:0] e_err, input logic e_fine);
    chk({tag, " err"}, err_out, e_err);
    chk({tag, " fine"}, {15'd0, fine_mode}, {15'd0, e_fine});
    chk({tag, " R6 bit"}, {15'd0, bit_fail}, {15'd0, ~e_fine});
  endtask

  task automatic apply(input logic [15:0] c, input logic [15:0] f, input logic [15:0] n);
    coarse_ang = c; fine_ang = f; cnt_ang = n;
    @(negedge clk);
  endtask

  initial begin
    n_run = 0; n_fail = 0; done = 0;
    rst_n = 1'b0;
    coarse_ang = 16'h1000; fine_ang = 16'h4010; cnt_ang = 16'h1000;
    repeat (3) @(negedge clk);
    chk_out("R1 in reset", 16'h0000, 1'b0);
    rst_n = 1'b1;
    #1;
    chk_out("R1 after release", 16'h0000, 1'b0);
    @(negedge clk);

    for (int i = 0; i < NVEC; i++) begin
      apply(VEC[i][79:64], VEC[i][63:48], VEC[i][47:32]);
      chk_out($sformatf("vec %0d", i), VEC[i][31:16], VEC[i][0]);
    end

    // R8: walk in and out of the capture window with counter 0x1000
    apply(16'h1000, 16'h4000, 16'h1000);
    chk_out("R8 in", 16'h0000, 1'b1);
    apply(16'h1100, 16'h4000, 16'h1000);
    chk_out("R8 stay", 16'h0000, 1'b1);
    apply(16'h11CD, 16'h4000, 16'h1000);
    chk_out("R8 out", 16'h0398, 1'b0);
    apply(16'h10C8, 16'h4003, 16'h1000);
    chk_out("R8 back", 16'h0003, 1'b1);

    // R9: asynchronous reset mid-run
    #2;
    rst_n = 1'b0;
    #1;
    chk_out("R9 async", 16'h0000, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    apply(16'h1000, 16'h4010, 16'h1000);
    chk_out("R9 resume", 16'h0010, 1'b1);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule